// File: doc/BRIEF.md
# Break-Protected Status Flag Logic

This block keeps a vector of peripheral status flags. Each flag is set by a one-cycle event pulse. It is cleared by a two-step access sequence. In the first step, software reads the status register while the flag is 1, and this arms a pending bit kept for that flag. In the second step, software accesses the data register tied to that flag, and the flag clears if its pending bit is armed.

While a debug break is active, the block shields the flags so that a debugger can read and write registers without destroying status. Clearing is suppressed unless a break-clear-enable control is 1. While clearing is suppressed, the pending bits are frozen as well. A sequence whose first step happened before the break can therefore finish normally once the break ends. Set events are never blocked.

Top module: `flag_status_guard`

## Requirements
- R1: After reset, every flag and every pending bit is 0, and `rd_data` is 0.
- R2: A 1 on `set_evt[i]` makes `flags[i]` 1 after the next rising clock edge, whether or not break is active.
- R3: Outside break, a cycle with `stat_rd`=1 while `flags[i]`=1 arms flag i. A later cycle with `data_acc[i]`=1 then clears `flags[i]` at that edge.
- R4: A `data_acc[i]` pulse with flag i not armed has no effect on `flags[i]`, and it disarms flag i.
- R5: While `brk_active`=1 and `brk_clr_en`=0, no combination of `stat_rd` and `data_acc` clears a flag.
- R6: While `brk_active`=1 and `brk_clr_en`=1, the two-step clear works exactly as in R3.
- R7: A flag cleared during break stays 0 after `brk_active` returns to 0.
- R8: While `brk_active`=1 and `brk_clr_en`=0, pending bits keep their value. A flag armed before the break therefore clears on its first `data_acc` after the break, with no new status read.
- R9: When `set_evt[i]` and a clearing `data_acc[i]` fall in the same cycle, `flags[i]` stays 1 and flag i is disarmed. A following `data_acc[i]` alone does not clear it.
- R10: `rd_data` equals `flags` combinationally while `stat_rd`=1, and is all zeros otherwise.
- R11: Each flag's arming and clearing is independent. A `data_acc[j]` never changes `flags[i]` for i different from j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_evt | input | NFLAGS | Per-flag set event pulses |
| brk_active | input | 1 | Debug break mode is active |
| brk_clr_en | input | 1 | Lets clearing work during break |
| stat_rd | input | 1 | Status register read strobe (first step) |
| data_acc | input | NFLAGS | Per-flag data register access strobes (second step) |
| flags | output | NFLAGS | Current flag values |
| rd_data | output | NFLAGS | Status read data, valid while `stat_rd` is 1 |

## Verification
Flag and pending state are registered, so the effect of any strobe or set pulse shows one rising edge after it is applied. The bench drives each stimulus at a falling edge and samples `flags` at the next falling edge, which is exactly one register stage later. `rd_data` has no register on its path. The bench therefore checks it a short delay after raising `stat_rd`, within the same cycle and before any edge. Pending bits are not visible at the ports. They are observed through the result of a later data access.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

  typedef struct packed {
    logic flag;
    logic pend;
  } fsg_state_t;

  // Next state of one flag/pending pair. allow = clearing permitted this cycle.
  function automatic fsg_state_t fsg_next(input fsg_state_t cur, input logic set,
                                          input logic rd, input logic acc,
                                          input logic allow);
    fsg_state_t nx;
    if (!allow) begin
      nx.flag = cur.flag | set;
      nx.pend = cur.pend;
    end else begin
      nx.flag = set ? 1'b1 : ((acc && cur.pend) ? 1'b0 : cur.flag);
      nx.pend = acc ? 1'b0 : (cur.pend | (rd & cur.flag));
    end
    return nx;
  endfunction

endpackage

// File: rtl/fsg_clear_gate.sv
module fsg_clear_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic brk_active,
  input  logic brk_clr_en,
  output logic clr_allow
);
  assign clr_allow = !brk_active || brk_clr_en;

  // R5/R6: clearing is allowed outside break, or in break with the enable set
  always_comb begin
    if (rst_n && brk_active) a_gate_r6: assert (clr_allow == brk_clr_en);
  end
endmodule

// File: rtl/fsg_flag_cell.sv
module fsg_flag_cell
  import fsg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic rd,
  input  logic acc,
  input  logic allow,
  output logic flag
);
  fsg_state_t st_q, st_d;
  logic       pend;
  logic       clear_evt;

  assign st_d      = fsg_next(st_q, set, rd, acc, allow);
  assign flag      = st_q.flag;
  assign pend      = st_q.pend;
  assign clear_evt = st_q.flag && !st_d.flag;

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag);
  p_no_clear_protected_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!allow && flag) |=> flag);
  p_pend_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !allow |=> pend == $past(pend));
  p_clear_needs_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clear_evt |=> ($past(pend) && $past(acc) && $past(allow) && !flag));
  p_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (allow && rd && flag && !acc) |=> pend);
  p_acc_disarms_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (allow && acc) |=> !pend);
endmodule

// File: rtl/flag_status_guard.sv
module flag_status_guard #(
  parameter int NFLAGS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NFLAGS-1:0] set_evt,
  input  logic              brk_active,
  input  logic              brk_clr_en,
  input  logic              stat_rd,
  input  logic [NFLAGS-1:0] data_acc,
  output logic [NFLAGS-1:0] flags,
  output logic [NFLAGS-1:0] rd_data
);
  logic clr_allow;

  fsg_clear_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .brk_active (brk_active),
    .brk_clr_en (brk_clr_en),
    .clr_allow  (clr_allow)
  );

  for (genvar i = 0; i < NFLAGS; i++) begin : g_cell
    fsg_flag_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (set_evt[i]),
      .rd    (stat_rd),
      .acc   (data_acc[i]),
      .allow (clr_allow),
      .flag  (flags[i])
    );
  end

  assign rd_data = stat_rd ? flags : '0;

  // R10: read path is quiet without a read strobe
  p_rd_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |-> rd_data == '0);
  // R7: once break ends, a cleared flag rises only through a set event
  p_stay_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(brk_active) |-> ((flags & ~$past(flags)) & ~$past(set_evt)) == '0);
endmodule

// File: tb/tb_flag_status_guard.sv
module tb_flag_status_guard;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] set_evt;
  logic         brk_active, brk_clr_en, stat_rd;
  logic [N-1:0] data_acc;
  logic [N-1:0] flags, rd_data;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  flag_status_guard #(.NFLAGS(N)) dut (
    .clk(clk), .rst_n(rst_n), .set_evt(set_evt), .brk_active(brk_active),
    .brk_clr_en(brk_clr_en), .stat_rd(stat_rd), .data_acc(data_acc),
    .flags(flags), .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // drive strobes for one cycle, then return one falling edge later
  task automatic step(input logic [N-1:0] s, input logic rd, input logic [N-1:0] a);
    set_evt = s; stat_rd = rd; data_acc = a;
    @(negedge clk);
    set_evt = '0; stat_rd = 1'b0; data_acc = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; brk_active = 1'b0; brk_clr_en = 1'b0;
    set_evt = '0; stat_rd = 1'b0; data_acc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 flags", flags, '0);
    chk("R1 rd_data", rd_data, '0);
    step('0, 1'b0, 4'b1111);       // access with nothing armed
    chk("R1 no pending after reset", flags, '0);
  endtask

  task automatic t_set_and_read();
    do_reset();
    step(4'b0101, 1'b0, '0);
    chk("R2 set", flags, 4'b0101);
    stat_rd = 1'b1; #1;
    chk("R10 read shows flags", rd_data, 4'b0101);
    stat_rd = 1'b0; #1;
    chk("R10 no read no data", rd_data, '0);
    brk_active = 1'b1;
    step(4'b1000, 1'b0, '0);
    chk("R2 set during break", flags, 4'b1101);
    brk_active = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_clear_normal();
    do_reset();
    step(4'b0011, 1'b0, '0);
    step('0, 1'b0, 4'b0001);
    chk("R4 unarmed access ignored", flags, 4'b0011);
    step('0, 1'b1, '0);
    step('0, 1'b0, 4'b0010);
    chk("R11 only flag1 cleared", flags, 4'b0001);
    step('0, 1'b0, 4'b0001);
    chk("R3 two-step clear", flags, 4'b0000);
    // R4: access disarms
    step(4'b0100, 1'b0, '0);
    step('0, 1'b1, '0);
    step('0, 1'b0, 4'b0100);
    step(4'b0100, 1'b0, '0);
    step('0, 1'b0, 4'b0100);
    chk("R4 disarmed after access", flags, 4'b0100);
  endtask

  task automatic t_break_blocked();
    do_reset();
    step(4'b0001, 1'b0, '0);
    brk_active = 1'b1; brk_clr_en = 1'b0;
    step('0, 1'b1, '0);
    step('0, 1'b0, 4'b0001);
    chk("R5 blocked in break", flags, 4'b0001);
    step('0, 1'b1, 4'b0001);
    chk("R5 blocked read+acc", flags, 4'b0001);
    brk_active = 1'b0;
    step('0, 1'b0, 4'b0001);
    chk("R8 break reads did not arm", flags, 4'b0001);
  endtask

  task automatic t_break_enabled();
    do_reset();
    step(4'b0010, 1'b0, '0);
    brk_active = 1'b1; brk_clr_en = 1'b1;
    step('0, 1'b1, '0);
    step('0, 1'b0, 4'b0010);
    chk("R6 clear in break with enable", flags, 4'b0000);
    brk_active = 1'b0; brk_clr_en = 1'b0;
    step('0, 1'b0, '0);
    step('0, 1'b0, '0);
    chk("R7 stays cleared after break", flags, 4'b0000);
  endtask

  task automatic t_arm_across_break();
    do_reset();
    step(4'b1000, 1'b0, '0);
    step('0, 1'b1, '0);            // armed before break
    brk_active = 1'b1; brk_clr_en = 1'b0;
    step('0, 1'b0, 4'b1000);
    chk("R8 protected in break", flags, 4'b1000);
    brk_active = 1'b0;
    step('0, 1'b0, 4'b1000);
    chk("R8 completes after break", flags, 4'b0000);
  endtask

  task automatic t_set_wins();
    do_reset();
    step(4'b0001, 1'b0, '0);
    step('0, 1'b1, '0);
    step(4'b0001, 1'b0, 4'b0001);
    chk("R9 set wins", flags, 4'b0001);
    step('0, 1'b0, 4'b0001);
    chk("R9 pending dropped", flags, 4'b0001);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_set_and_read();
    t_clear_normal();
    t_break_blocked();
    t_break_enabled();
    t_arm_across_break();
    t_set_wins();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule